// File: doc/BRIEF.md
# Watermark-Gated PIO Data Buffer

This block is the word buffer that sits between a host register port and the card-side data stream of an SD host controller. Software moves data one 32-bit word at a time through a data register. On the card side, a valid/ready word stream fills the buffer for transfers from the card and drains it for transfers to the card. A control bit picks which of the two directions is active.

The host does not poll for every word. Two programmable thresholds decide when a ready bit is raised. The read-ready bit rises when enough words are stored. The write-ready bit rises when enough slots are free. Each time a ready bit rises, the host receives a budget equal to the threshold. After it has spent that budget, the bit drops and is re-armed only when the buffer again holds, or has room for, a full threshold's worth of words. With both thresholds at 128 words, a single ready event covers an entire 512-byte block. Software that moves a full block per event then behaves correctly.

An access beyond the budget is refused and recorded in a sticky error flag. Each rising ready bit also latches a sticky event bit. The interrupt lines are those event bits masked by their enables.

Top module: `pio_wm_buffer`

## Requirements
- R1: After reset, the register at offset 0x44 reads 0x10401040. The status (0x04), event (0x08) and control (0x0C) registers read 0. The interrupt lines are low, `card_in_ready` is 1 and `card_out_valid` is 0.
- R2: All 32 bits of the threshold register at 0x44 are plain read/write storage. The read threshold sits in bits 7:0 and the write threshold in bits 23:16. Both read back exactly as written, with no clamping applied.
- R3: A threshold field of 0 acts as 1. A field above DEPTH acts as DEPTH.
- R4: In the card-to-host direction (control bit 0 = 0), with no read budget left, read-ready (status bit 0) rises once the fill level (status bits 23:16) reaches the effective read threshold. When it rises, the budget is set to the threshold and event bit 0 is set.
- R5: Each data-port read (offset 0x00) made within the budget returns the next stored word in arrival order and uses one unit of budget. When the budget reaches zero, read-ready drops. It rises again only once another threshold's worth of words is stored.
- R6: A data-port read made with no read budget returns 0, leaves the buffer contents untouched and sets the sticky overrun flag (status bit 2).
- R7: In the host-to-card direction (control bit 0 = 1), with no write budget left, write-ready (status bit 1) rises once the number of free slots reaches the effective write threshold. When it rises, the budget is set to the threshold and event bit 1 is set. Each data-port write within the budget stores one word.
- R8: A data-port write made with no write budget is discarded and sets the sticky underrun flag (status bit 3).
- R9: The event bits at 0x08 clear when 1 is written to them. `irq_rd` equals event bit 0 AND enable bit 1 of control. `irq_wr` equals event bit 1 AND enable bit 2 of control.
- R10: In the card-to-host direction, `card_in_ready` is high exactly when the buffer is not full, and `card_out_valid` stays low. In the host-to-card direction, `card_out_valid` is high exactly when the buffer is not empty, words leave in the order they were written, and `card_in_ready` stays low.
- R11: Writing control with a direction bit different from the current one empties the buffer and clears both budgets.
- R12: The overrun and underrun flags clear when 1 is written to status bits 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | AW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid the cycle after `reg_rd` |
| irq_rd | output | 1 | Read-ready interrupt |
| irq_wr | output | 1 | Write-ready interrupt |
| card_in_valid | input | 1 | Card word offered to the buffer |
| card_in_data | input | 32 | Card word |
| card_in_ready | output | 1 | Buffer accepts the card word |
| card_out_valid | output | 1 | Buffer offers a word to the card |
| card_out_data | output | 32 | Word to the card |
| card_out_ready | input | 1 | Card takes the offered word |

## Verification
Register read data appears at the clock edge that samples `reg_rd`, so the bench reads it at the following falling edge. A ready bit is reloaded one edge after the fill level or free space crosses its threshold, so the bench leaves one idle cycle after any fill, drain or data-port access before it reads status. Card-side handshake outputs are combinational on the fill level, so they are checked at the falling edge right after the last transfer. The bench sweeps both thresholds across 0 to DEPTH+2 in a small configuration, and the expected ready state, level and data order are computed arithmetically for each value.

// File: rtl/pio_wm_buffer.sv
module pio_wm_buffer #(
  parameter int DEPTH = 128,
  parameter int AW = 8,
  parameter logic [31:0] WM_RESET = 32'h1040_1040
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          irq_rd,
  output logic          irq_wr,
  input  logic          card_in_valid,
  input  logic [31:0]   card_in_data,
  output logic          card_in_ready,
  output logic          card_out_valid,
  output logic [31:0]   card_out_data,
  input  logic          card_out_ready
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [AW-1:0] A_DATA  = AW'(8'h00);
  localparam logic [AW-1:0] A_STAT  = AW'(8'h04);
  localparam logic [AW-1:0] A_EVT   = AW'(8'h08);
  localparam logic [AW-1:0] A_CTRL  = AW'(8'h0C);
  localparam logic [AW-1:0] A_WMARK = AW'(8'h44);

  logic [31:0]   mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic [CW-1:0] level, rd_budget, wr_budget;
  logic          dir, rd_ie, wr_ie, overrun, underrun;
  logic [1:0]    irq_sts;
  logic [31:0]   wm_reg;

  function automatic logic [CW-1:0] clamp_wm(input logic [7:0] f);
    if (f == 8'd0) return CW'(1);
    if (32'(f) > DEPTH) return FULL;
    return CW'(f);
  endfunction

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  wire [CW-1:0] rd_wm = clamp_wm(wm_reg[7:0]);
  wire [CW-1:0] wr_wm = clamp_wm(wm_reg[23:16]);

  wire sel_data = reg_addr == A_DATA;
  wire sel_stat = reg_addr == A_STAT;
  wire sel_evt  = reg_addr == A_EVT;
  wire sel_ctrl = reg_addr == A_CTRL;
  wire sel_wm   = reg_addr == A_WMARK;

  wire dat_rd    = reg_rd && sel_data;
  wire dat_wr    = reg_wr && sel_data;
  wire host_pop  = dat_rd && !dir && rd_budget != '0;
  wire host_push = dat_wr && dir && wr_budget != '0;

  assign card_in_ready  = !dir && level != FULL;
  assign card_out_valid = dir && level != '0;
  assign card_out_data  = mem[rptr];

  wire card_push = card_in_valid && card_in_ready;
  wire card_pop  = card_out_valid && card_out_ready;
  wire push      = host_push || card_push;
  wire pop       = host_pop || card_pop;
  wire [31:0] wdat = dir ? reg_wdata : card_in_data;

  wire flush   = reg_wr && sel_ctrl && (reg_wdata[0] != dir);
  wire rd_load = !flush && !dir && rd_budget == '0 && level >= rd_wm;
  wire wr_load = !flush && dir && wr_budget == '0 && (FULL - level) >= wr_wm;

  wire [1:0] evt_clr = (reg_wr && sel_evt) ? reg_wdata[1:0] : 2'b00;
  wire [1:0] err_clr = (reg_wr && sel_stat) ? reg_wdata[3:2] : 2'b00;

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= wdat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else if (flush) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (push) wptr <= step(wptr);
      if (pop)  rptr <= step(rptr);
      level <= level + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_budget <= '0;
      wr_budget <= '0;
    end else if (flush) begin
      rd_budget <= '0;
      wr_budget <= '0;
    end else begin
      if (host_pop)     rd_budget <= rd_budget - 1'b1;
      else if (rd_load) rd_budget <= rd_wm;
      if (host_push)    wr_budget <= wr_budget - 1'b1;
      else if (wr_load) wr_budget <= wr_wm;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir      <= 1'b0;
      rd_ie    <= 1'b0;
      wr_ie    <= 1'b0;
      wm_reg   <= WM_RESET;
      irq_sts  <= 2'b00;
      overrun  <= 1'b0;
      underrun <= 1'b0;
    end else begin
      if (reg_wr && sel_ctrl) begin
        dir   <= reg_wdata[0];
        rd_ie <= reg_wdata[1];
        wr_ie <= reg_wdata[2];
      end
      if (reg_wr && sel_wm) wm_reg <= reg_wdata;
      irq_sts  <= (irq_sts & ~evt_clr) | {wr_load, rd_load};
      overrun  <= (overrun && !err_clr[0]) || (dat_rd && !host_pop);
      underrun <= (underrun && !err_clr[1]) || (dat_wr && !host_push);
    end
  end

  assign irq_rd = irq_sts[0] && rd_ie;
  assign irq_wr = irq_sts[1] && wr_ie;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_rdata <= '0;
    else if (reg_rd) begin
      unique case (1'b1)
        sel_data: reg_rdata <= host_pop ? mem[rptr] : 32'h0;
        sel_stat: reg_rdata <= {8'h00, 8'(level), 12'h000, underrun, overrun,
                                wr_budget != '0, rd_budget != '0};
        sel_evt:  reg_rdata <= {30'h0, irq_sts};
        sel_ctrl: reg_rdata <= {29'h0, wr_ie, rd_ie, dir};
        sel_wm:   reg_rdata <= wm_reg;
        default:  reg_rdata <= 32'h0;
      endcase
    end
  end
endmodule

// File: rtl/pio_wm_buffer_chk.sv
module pio_wm_buffer_chk #(
  parameter int DEPTH = 128,
  parameter int AW = 8,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_rd,
  input logic          reg_wr,
  input logic [AW-1:0] reg_addr,
  input logic          wdat0,
  input logic [31:0]   reg_rdata,
  input logic          dir,
  input logic [CW-1:0] level,
  input logic [CW-1:0] rd_budget,
  input logic [CW-1:0] wr_budget,
  input logic [1:0]    irq_sts,
  input logic          overrun
);
  localparam logic [AW-1:0] A_DATA = AW'(8'h00);
  localparam logic [AW-1:0] A_CTRL = AW'(8'h0C);

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    32'(level) <= DEPTH);

  p_rd_budget_covered_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !dir |-> rd_budget <= level);

  p_wr_budget_covered_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dir |-> (32'(wr_budget) + 32'(level)) <= DEPTH);

  p_rd_rise_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_budget != '0) |-> irq_sts[0]);

  p_wr_rise_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_budget != '0) |-> irq_sts[1]);

  p_overrun_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == A_DATA && rd_budget == '0) |=> (reg_rdata == 32'h0 && overrun));

  p_dir_flush_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_CTRL && wdat0 != dir) |=>
      (level == '0 && rd_budget == '0 && wr_budget == '0));
endmodule

bind pio_wm_buffer pio_wm_buffer_chk #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .wdat0(reg_wdata[0]), .reg_rdata(reg_rdata), .dir(dir), .level(level),
  .rd_budget(rd_budget), .wr_budget(wr_budget), .irq_sts(irq_sts), .overrun(overrun)
);

// File: tb/pio_wm_buffer_tb_top.sv
`timescale 1ns/1ps
module pio_wm_buffer_tb_top;
  localparam int D = 8;
  localparam logic [7:0] A_DATA = 8'h00, A_STAT = 8'h04, A_EVT = 8'h08,
                         A_CTRL = 8'h0C, A_WM = 8'h44;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata, card_in_data = '0, card_out_data;
  logic irq_rd, irq_wr, card_in_valid = 1'b0, card_in_ready;
  logic card_out_valid, card_out_ready = 1'b0;

  pio_wm_buffer #(.DEPTH(D), .AW(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_rd(irq_rd), .irq_wr(irq_wr),
    .card_in_valid(card_in_valid), .card_in_data(card_in_data), .card_in_ready(card_in_ready),
    .card_out_valid(card_out_valid), .card_out_data(card_out_data), .card_out_ready(card_out_ready)
  );

  int vec = 0, bad = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic push(input logic [31:0] d);
    card_in_valid = 1'b1; card_in_data = d;
    @(negedge clk);
    card_in_valid = 1'b0;
  endtask

  task automatic pop(output logic [31:0] d);
    d = card_out_data; card_out_ready = 1'b1;
    @(negedge clk);
    card_out_ready = 1'b0;
  endtask

  function automatic int eff(input int wm);
    if (wm == 0) return 1;
    if (wm > D) return D;
    return wm;
  endfunction

  function automatic logic [31:0] stat(input bit rr, input bit wrd, input bit ov, input bit un, input int lvl);
    return {8'h00, 8'(lvl), 12'h000, un, ov, wrd, rr};
  endfunction

  function automatic logic [31:0] rword(input int wm, input int k);
    return 32'hA000_0000 + 32'(wm * 256 + k);
  endfunction

  function automatic logic [31:0] wword(input int wm, input int k);
    return 32'hC000_0000 + 32'(wm * 256 + k);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      vec++; bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    chk("R1", "irq_rd", 32'(irq_rd), 0);
    chk("R1", "irq_wr", 32'(irq_wr), 0);
    chk("R1", "card_in_ready", 32'(card_in_ready), 1);
    chk("R1", "card_out_valid", 32'(card_out_valid), 0);
    rd(A_WM, d);   chk("R1", "wm reset", d, 32'h1040_1040);
    rd(A_STAT, d); chk("R1", "status reset", d, 0);
    rd(A_EVT, d);  chk("R1", "event reset", d, 0);
    rd(A_CTRL, d); chk("R1", "ctrl reset", d, 0);

    // R2 threshold register storage
    begin
      logic [31:0] pats [4] = '{32'hFFFF_FFFF, 32'h0000_0000, 32'h5A5A_A5A5, 32'h00FF_00C8};
      foreach (pats[i]) begin
        wr(A_WM, pats[i]);
        rd(A_WM, d);
        chk("R2", "wm readback", d, pats[i]);
      end
    end

    // R3 R4 R5 R6 R12: read-side sweep over the read threshold
    for (int wm = 0; wm <= D + 2; wm++) begin
      int e;
      e = eff(wm);
      wr(A_WM, 32'(wm));
      wr(A_CTRL, 32'h1);
      wr(A_CTRL, 32'h0);
      wr(A_EVT, 32'h3);
      for (int k = 1; k <= e; k++) begin
        push(rword(wm, k));
        idle(1);
        rd(A_STAT, d);
        chk("R3 R4", $sformatf("wm=%0d fill %0d", wm, k), d, stat(k >= e, 0, 0, 0, k));
      end
      if (e == D) chk("R10", "full blocks card", 32'(card_in_ready), 0);
      chk("R10", "no out in read dir", 32'(card_out_valid), 0);
      rd(A_EVT, d); chk("R4", $sformatf("wm=%0d event", wm), d, 32'h1);
      for (int k = 1; k <= e; k++) begin
        rd(A_DATA, d);
        chk("R5", $sformatf("wm=%0d word %0d", wm, k), d, rword(wm, k));
      end
      idle(1);
      rd(A_STAT, d); chk("R5", "ready drops", d, stat(0, 0, 0, 0, 0));
      rd(A_DATA, d); chk("R6", "overrun data", d, 0);
      rd(A_STAT, d); chk("R6", "overrun flag", d, stat(0, 0, 1, 0, 0));
      wr(A_STAT, 32'h4);
      rd(A_STAT, d); chk("R12", "overrun clear", d, 0);
      wr(A_EVT, 32'h1);
      rd(A_EVT, d); chk("R9", "event w1c", d, 0);
      if (e > 1) begin
        for (int k = 1; k < e; k++) push(rword(wm, 100 + k));
        idle(1);
        rd(A_STAT, d); chk("R5", "no early rearm", d, stat(0, 0, 0, 0, e - 1));
      end
      push(rword(wm, 200));
      idle(1);
      rd(A_STAT, d); chk("R5", "rearm", d, stat(1, 0, 0, 0, e));
      rd(A_EVT, d);  chk("R5", "rearm event", d, 32'h1);
    end

    // R3 R7 R8 R10 R12: write-side sweep over the write threshold
    for (int wm = 0; wm <= D + 2; wm++) begin
      int e;
      bit again;
      e = eff(wm);
      again = (D - e) >= e;
      wr(A_WM, 32'(wm) << 16);
      wr(A_CTRL, 32'h0);
      wr(A_EVT, 32'h3);
      wr(A_CTRL, 32'h1);
      idle(1);
      rd(A_STAT, d); chk("R7", $sformatf("wm=%0d empty ready", wm), d, stat(0, 1, 0, 0, 0));
      rd(A_EVT, d);  chk("R7", "write event", d, 32'h2);
      for (int k = 0; k < e; k++) wr(A_DATA, wword(wm, k));
      idle(1);
      rd(A_STAT, d); chk("R3 R7", $sformatf("wm=%0d after budget", wm), d, stat(0, again, 0, 0, e));
      if (!again) begin
        wr(A_DATA, 32'hDEAD_BEEF);
        rd(A_STAT, d); chk("R8", "underrun", d, stat(0, 0, 0, 1, e));
        wr(A_STAT, 32'h8);
        rd(A_STAT, d); chk("R12", "underrun clear", d, stat(0, 0, 0, 0, e));
      end
      chk("R10", "no in in write dir", 32'(card_in_ready), 0);
      for (int k = 0; k < e; k++) begin
        chk("R10", "out valid", 32'(card_out_valid), 1);
        pop(d);
        chk("R10", $sformatf("wm=%0d out word %0d", wm, k), d, wword(wm, k));
      end
      chk("R10", "out empty", 32'(card_out_valid), 0);
      idle(1);
      rd(A_STAT, d); chk("R7", "drained ready", d, stat(0, 1, 0, 0, 0));
    end

    // R9 interrupt masking
    wr(A_WM, 32'h0000_0002);
    wr(A_CTRL, 32'h1);
    wr(A_CTRL, 32'h0);
    wr(A_EVT, 32'h3);
    wr(A_CTRL, 32'h2);
    push(32'h11); push(32'h22);
    idle(1);
    chk("R9", "irq_rd set", 32'(irq_rd), 1);
    chk("R9", "irq_wr quiet", 32'(irq_wr), 0);
    wr(A_EVT, 32'h1);
    chk("R9", "irq_rd cleared", 32'(irq_rd), 0);
    wr(A_CTRL, 32'h0);
    rd(A_DATA, d); rd(A_DATA, d);
    push(32'h33); push(32'h44);
    idle(1);
    rd(A_EVT, d); chk("R9", "event without enable", d, 32'h1);
    chk("R9", "masked irq", 32'(irq_rd), 0);

    // R11 direction change flushes
    push(32'h55);
    rd(A_STAT, d); chk("R11", "pre-flush level", d, stat(1, 0, 0, 0, 3));
    wr(A_CTRL, 32'h1);
    rd(A_STAT, d); chk("R11", "flushed", d, stat(0, 0, 0, 0, 0));
    chk("R11", "nothing to card", 32'(card_out_valid), 0);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule